// File: doc/BRIEF.md
# Variable-Page Fully Associative Data TLB

This block translates a data virtual address into a 41-bit physical address by searching every entry of a fully associative buffer in one cycle. Each entry pairs a 64-bit virtual tag with a 64-bit translation word. The translation word sets the entry's page size, its global flag, its access restrictions and its physical frame. A request carries the virtual address, the access kind (load, store or non-faulting load), a context select with the primary and secondary context values, and the privilege state. The block answers in the same cycle with hit, grant, write permission, physical address and any trap.

On a fault or a miss, the tag-access, fault-status and fault-address registers update on the clock edge that ends the lookup cycle. A clean hit sets the entry's used bit on that same edge. Software fills entries through a single write port and can read one entry back by index. Refill after a miss is left to software. With translation disabled, addresses pass straight through.

Top module: `dtlb_xlate`

## Requirements
- R1: After reset, every entry reads back as zero (invalid). The status, fault-address and tag-access registers read zero. A lookup with translation enabled misses.
- R2: An entry matches only when its translation word bit 63 (valid) is set and the virtual address equals the tag above the page offset. The offset is 13, 16, 19 or 22 bits for page-size field bits [62:61] = 0, 1, 2, 3.
- R3: The selected context is the primary value for select 0, the secondary value for select 1, and 0 for select 2 (a select of 3 acts as 2). A non-global entry also needs its tag bits [12:0] to equal this context. An entry with translation bit 0 set skips the context compare.
- R4: On a granted hit, physical address bits [40:offset] come from the translation word and the bits below the offset come from the virtual address.
- R5: When several entries match, the lowest index is used.
- R6: A data fault (trap 0x09) arises for any of three cases: a user access (privilege input low) to a page with bit 2 set; a non-faulting load to a page with bit 3 set; a load or store to a page with bit 60 set. The status gets bit 7, 8 and 11 respectively for these, and more than one may be set at once.
- R7: Without a data fault, a store to a page whose bit 1 is clear raises the protection trap 0x6C. A granted hit reports write permission equal to bit 1.
- R8: On a fault the status register becomes: bit 0 set; bit 2 for a store; bit 3 for the privilege input; bits [5:4] the context kind (0 primary, 1 secondary, 2 nucleus); bit 24 for a non-faulting load; plus the fault-type bits. The fault-address register takes the full virtual address.
- R9: On a fault while status bit 0 is already set, status bit 1 (overflow) is set.
- R10: A miss raises trap 0x68 and leaves the status and fault-address registers unchanged.
- R11: On any miss or fault the tag-access register takes virtual address bits [63:13] above the 13-bit selected context.
- R12: A granted hit sets translation bit 41 of the hit entry on the next clock edge.
- R13: With the enable input low, a lookup is granted with write permission, no hit and no trap. The physical address is the virtual address truncated to 41 bits, and no register changes.
- R14: The write port stores tag and translation word at the given index on the next edge. A write to the hit entry in the same cycle overrides the used-bit update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Entry write strobe |
| wrIdx | input | 6 | Entry index to write |
| wrTag | input | 64 | Virtual tag, context in bits [12:0] |
| wrTte | input | 64 | Translation word |
| rdIdx | input | 6 | Entry index to read back |
| rdTte | output | 64 | Translation word at rdIdx |
| lookupEn | input | 1 | A lookup is presented this cycle |
| mmuEnable | input | 1 | Translation enable |
| vaddr | input | 64 | Virtual address |
| accKind | input | 2 | 0 load, 1 store, 2 non-faulting load |
| ctxSel | input | 2 | 0 primary, 1 secondary, 2 nucleus |
| priCtx | input | 13 | Primary context value |
| secCtx | input | 13 | Secondary context value |
| privMode | input | 1 | Access made in privileged mode |
| hit | output | 1 | An entry matched |
| grant | output | 1 | Access allowed, paddr valid |
| permWrite | output | 1 | Granted page is writable |
| paddr | output | 41 | Physical address (zero unless granted) |
| trapValid | output | 1 | A trap is raised |
| trapType | output | 8 | Trap code |
| faultStatus | output | 64 | Fault status register |
| faultAddr | output | 64 | Fault address register |
| tagAccess | output | 64 | Tag-access register |

## Verification
Hit, grant, write permission, physical address and trap are combinational and due in the cycle the lookup is presented. The bench drives each request just after a rising edge and compares these outputs at the following falling edge. The three registers, the used bit and written entries change on the next rising edge. They are therefore compared at the falling edge one cycle later, against a behavioural model that advances its own state only after each comparison.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
  localparam int VA_W     = 64;
  localparam int PA_W     = 41;
  localparam int CTX_W    = 13;
  localparam int BASE_OFF = 13;

  localparam int B_VALID = 63;
  localparam int B_NFO   = 60;
  localparam int B_USED  = 41;
  localparam int B_SIDE  = 3;
  localparam int B_PRIV  = 2;
  localparam int B_WOK   = 1;
  localparam int B_GLOB  = 0;

  typedef enum logic [1:0] {ACC_LOAD = 2'd0, ACC_STORE = 2'd1, ACC_NFLOAD = 2'd2} accKind_e;

  typedef struct packed {
    logic nfo;
    logic side;
    logic priv;
    logic wok;
  } pageFlags_t;

  typedef struct packed {
    logic markUsed;
    logic lookupLive;
  } dpStrobe_t;

  function automatic logic [VA_W-1:0] offMask(input logic [1:0] sz);
    int b;
    b = BASE_OFF + 3 * int'(sz);
    return (64'h1 << b) - 64'h1;
  endfunction
endpackage

// File: rtl/dtlb_datapath.sv
module dtlb_datapath
  import dtlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [VA_W-1:0]   wrTag,
  input  logic [VA_W-1:0]   wrTte,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [VA_W-1:0]   rdTte,
  input  logic [VA_W-1:0]   vaddr,
  input  logic [CTX_W-1:0]  ctxVal,
  input  dpStrobe_t         strobe,
  output logic              anyHit,
  output pageFlags_t        hitFlags,
  output logic [PA_W-1:0]   paddrMap
);
  logic [VA_W-1:0]    tagMem [ENTRIES];
  logic [VA_W-1:0]    tteMem [ENTRIES];
  logic [ENTRIES-1:0] matchVec;
  logic [IDX_W-1:0]   hitIdx;
  logic [VA_W-1:0]    hitMask;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic [VA_W-1:0] keepMask;
    logic            vaEq;
    logic            ctxEq;
    assign keepMask    = ~offMask(tteMem[i][62:61]);
    assign vaEq        = ((vaddr ^ tagMem[i]) & keepMask) == '0;
    assign ctxEq       = tteMem[i][B_GLOB] || (tagMem[i][CTX_W-1:0] == ctxVal);
    assign matchVec[i] = strobe.lookupLive && tteMem[i][B_VALID] && vaEq && ctxEq;
  end

  always_comb begin
    hitIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) hitIdx = IDX_W'(i);
    end
  end

  assign anyHit        = |matchVec;
  assign hitFlags.nfo  = tteMem[hitIdx][B_NFO];
  assign hitFlags.side = tteMem[hitIdx][B_SIDE];
  assign hitFlags.priv = tteMem[hitIdx][B_PRIV];
  assign hitFlags.wok  = tteMem[hitIdx][B_WOK];
  assign hitMask       = offMask(tteMem[hitIdx][62:61]);
  assign paddrMap      = (tteMem[hitIdx][PA_W-1:0] & ~hitMask[PA_W-1:0])
                       | (vaddr[PA_W-1:0] & hitMask[PA_W-1:0]);
  assign rdTte         = tteMem[rdIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tagMem[i] <= '0;
        tteMem[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wrEn && wrIdx == IDX_W'(i)) begin
          tagMem[i] <= wrTag;
          tteMem[i] <= wrTte;
        end else if (strobe.markUsed && hitIdx == IDX_W'(i)) begin
          tteMem[i][B_USED] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dtlb_ctrl.sv
module dtlb_ctrl
  import dtlb_pkg::*;
#(
  parameter logic [7:0] TRAP_DFAULT = 8'h09,
  parameter logic [7:0] TRAP_PROT   = 8'h6C,
  parameter logic [7:0] TRAP_MISS   = 8'h68
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupEn,
  input  logic             mmuEnable,
  input  logic [1:0]       accKind,
  input  logic [1:0]       ctxSel,
  input  logic [CTX_W-1:0] priCtx,
  input  logic [CTX_W-1:0] secCtx,
  input  logic             privMode,
  input  logic [VA_W-1:0]  vaddr,
  input  logic             anyHit,
  input  pageFlags_t       hitFlags,
  input  logic [PA_W-1:0]  paddrMap,
  output logic [CTX_W-1:0] ctxVal,
  output dpStrobe_t        strobe,
  output logic             hit,
  output logic             grant,
  output logic             permWrite,
  output logic [PA_W-1:0]  paddr,
  output logic             trapValid,
  output logic [7:0]       trapType,
  output logic [VA_W-1:0]  faultStatus,
  output logic [VA_W-1:0]  faultAddr,
  output logic [VA_W-1:0]  tagAccess
);
  logic       active, isStore, isNf, isUser;
  logic       ftPriv, ftSide, ftNfo, dataFault, protFault, anyFault;
  logic [1:0] ctxKind;
  logic [VA_W-1:0] newStatus;

  assign active  = lookupEn && mmuEnable;
  assign isStore = accKind == ACC_STORE;
  assign isNf    = accKind == ACC_NFLOAD;
  assign isUser  = !privMode;
  assign ctxKind = (ctxSel == 2'd3) ? 2'd2 : ctxSel;

  always_comb begin
    case (ctxKind)
      2'd0:    ctxVal = priCtx;
      2'd1:    ctxVal = secCtx;
      default: ctxVal = '0;
    endcase
  end

  assign ftPriv    = hitFlags.priv && isUser;
  assign ftSide    = isNf && hitFlags.side;
  assign ftNfo     = !isNf && hitFlags.nfo;
  assign dataFault = anyHit && (ftPriv || ftSide || ftNfo);
  assign protFault = anyHit && !dataFault && isStore && !hitFlags.wok;
  assign anyFault  = dataFault || protFault;

  assign strobe.lookupLive = active;
  assign strobe.markUsed   = active && anyHit && !anyFault;

  always_comb begin
    hit       = 1'b0;
    grant     = 1'b0;
    permWrite = 1'b0;
    paddr     = '0;
    trapValid = 1'b0;
    trapType  = '0;
    if (lookupEn && !mmuEnable) begin
      grant     = 1'b1;
      permWrite = 1'b1;
      paddr     = vaddr[PA_W-1:0];
    end else if (active) begin
      hit = anyHit;
      if (!anyHit) begin
        trapValid = 1'b1;
        trapType  = TRAP_MISS;
      end else if (dataFault) begin
        trapValid = 1'b1;
        trapType  = TRAP_DFAULT;
      end else if (protFault) begin
        trapValid = 1'b1;
        trapType  = TRAP_PROT;
      end else begin
        grant     = 1'b1;
        permWrite = hitFlags.wok;
        paddr     = paddrMap;
      end
    end
  end

  always_comb begin
    newStatus     = '0;
    newStatus[0]  = 1'b1;
    newStatus[1]  = faultStatus[0];
    newStatus[2]  = isStore;
    newStatus[3]  = privMode;
    newStatus[5:4] = ctxKind;
    newStatus[7]  = dataFault && ftPriv;
    newStatus[8]  = dataFault && ftSide;
    newStatus[11] = dataFault && ftNfo;
    newStatus[24] = isNf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultStatus <= '0;
      faultAddr   <= '0;
      tagAccess   <= '0;
    end else if (active) begin
      if (!anyHit || anyFault) tagAccess <= {vaddr[VA_W-1:BASE_OFF], ctxVal};
      if (anyFault) begin
        faultStatus <= newStatus;
        faultAddr   <= vaddr;
      end
    end
  end
endmodule

// File: rtl/dtlb_xlate.sv
module dtlb_xlate
  import dtlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter logic [7:0] TRAP_DFAULT = 8'h09,
  parameter logic [7:0] TRAP_PROT   = 8'h6C,
  parameter logic [7:0] TRAP_MISS   = 8'h68,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [63:0]      wrTag,
  input  logic [63:0]      wrTte,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [63:0]      rdTte,
  input  logic             lookupEn,
  input  logic             mmuEnable,
  input  logic [63:0]      vaddr,
  input  logic [1:0]       accKind,
  input  logic [1:0]       ctxSel,
  input  logic [12:0]      priCtx,
  input  logic [12:0]      secCtx,
  input  logic             privMode,
  output logic             hit,
  output logic             grant,
  output logic             permWrite,
  output logic [40:0]      paddr,
  output logic             trapValid,
  output logic [7:0]       trapType,
  output logic [63:0]      faultStatus,
  output logic [63:0]      faultAddr,
  output logic [63:0]      tagAccess
);
  logic [CTX_W-1:0] ctxVal;
  dpStrobe_t        strobe;
  logic             anyHit;
  pageFlags_t       hitFlags;
  logic [PA_W-1:0]  paddrMap;

  dtlb_datapath #(.ENTRIES(ENTRIES)) dp_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrTag(wrTag),
    .wrTte(wrTte), .rdIdx(rdIdx), .rdTte(rdTte), .vaddr(vaddr),
    .ctxVal(ctxVal), .strobe(strobe), .anyHit(anyHit),
    .hitFlags(hitFlags), .paddrMap(paddrMap)
  );

  dtlb_ctrl #(.TRAP_DFAULT(TRAP_DFAULT), .TRAP_PROT(TRAP_PROT), .TRAP_MISS(TRAP_MISS)) ctl_i (
    .clk(clk), .rstN(rstN), .lookupEn(lookupEn), .mmuEnable(mmuEnable),
    .accKind(accKind), .ctxSel(ctxSel), .priCtx(priCtx), .secCtx(secCtx),
    .privMode(privMode), .vaddr(vaddr), .anyHit(anyHit), .hitFlags(hitFlags),
    .paddrMap(paddrMap), .ctxVal(ctxVal), .strobe(strobe), .hit(hit),
    .grant(grant), .permWrite(permWrite), .paddr(paddr),
    .trapValid(trapValid), .trapType(trapType), .faultStatus(faultStatus),
    .faultAddr(faultAddr), .tagAccess(tagAccess)
  );
endmodule

// File: rtl/dtlb_xlate_chk.sv
module dtlb_xlate_chk #(
  parameter logic [7:0] TRAP_MISS = 8'h68
) (
  input logic        clk,
  input logic        rstN,
  input logic        lookupEn,
  input logic        mmuEnable,
  input logic [1:0]  accKind,
  input logic [63:0] vaddr,
  input logic        hit,
  input logic        grant,
  input logic        permWrite,
  input logic [40:0] paddr,
  input logic        trapValid,
  input logic [7:0]  trapType,
  input logic [63:0] faultStatus,
  input logic [63:0] faultAddr
);
  assert_grant_or_trap_R6: assert property (@(posedge clk) disable iff (!rstN)
    lookupEn |-> $onehot0({grant, trapValid}));

  assert_passthru_R13: assert property (@(posedge clk) disable iff (!rstN)
    (lookupEn && !mmuEnable) |-> (grant && permWrite && !hit && !trapValid && paddr == vaddr[40:0]));

  assert_miss_trap_R10: assert property (@(posedge clk) disable iff (!rstN)
    (lookupEn && mmuEnable && !hit) |-> (trapValid && trapType == TRAP_MISS));

  assert_miss_keeps_status_R10: assert property (@(posedge clk) disable iff (!rstN)
    (lookupEn && mmuEnable && !hit) |=> ($stable(faultStatus) && $stable(faultAddr)));

  assert_fault_logged_R8: assert property (@(posedge clk) disable iff (!rstN)
    (lookupEn && mmuEnable && hit && trapValid) |=> (faultStatus[0] && faultAddr == $past(vaddr)));

  assert_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    (lookupEn && mmuEnable && hit && trapValid && faultStatus[0]) |=> faultStatus[1]);

  assert_store_needs_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (lookupEn && mmuEnable && grant && accKind == 2'd1) |-> permWrite);
endmodule

bind dtlb_xlate dtlb_xlate_chk #(.TRAP_MISS(TRAP_MISS)) chk_i (
  .clk(clk), .rstN(rstN), .lookupEn(lookupEn), .mmuEnable(mmuEnable),
  .accKind(accKind), .vaddr(vaddr), .hit(hit), .grant(grant),
  .permWrite(permWrite), .paddr(paddr), .trapValid(trapValid),
  .trapType(trapType), .faultStatus(faultStatus), .faultAddr(faultAddr)
);

// File: tb/dtlb_xlate_tb_top.sv
module dtlb_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  wrIdx = '0;
  logic [63:0] wrTag = '0, wrTte = '0;
  logic [5:0]  rdIdx = '0;
  logic [63:0] rdTte;
  logic        lookupEn = 1'b0, mmuEnable = 1'b1;
  logic [63:0] vaddr = '0;
  logic [1:0]  accKind = '0, ctxSel = '0;
  logic [12:0] priCtx = '0, secCtx = '0;
  logic        privMode = 1'b0;
  logic        hit, grant, permWrite, trapValid;
  logic [40:0] paddr;
  logic [7:0]  trapType;
  logic [63:0] faultStatus, faultAddr, tagAccess;

  int nChecks = 0;
  int nFails  = 0;

  logic [63:0] mTag [64];
  logic [63:0] mTte [64];
  logic [63:0] mStatus = '0, mFaddr = '0, mTagAcc = '0;

  always #2 clk = ~clk;

  dtlb_xlate dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrTag(wrTag),
    .wrTte(wrTte), .rdIdx(rdIdx), .rdTte(rdTte), .lookupEn(lookupEn),
    .mmuEnable(mmuEnable), .vaddr(vaddr), .accKind(accKind), .ctxSel(ctxSel),
    .priCtx(priCtx), .secCtx(secCtx), .privMode(privMode), .hit(hit),
    .grant(grant), .permWrite(permWrite), .paddr(paddr), .trapValid(trapValid),
    .trapType(trapType), .faultStatus(faultStatus), .faultAddr(faultAddr),
    .tagAccess(tagAccess)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mkTte(input int sz, input logic [63:0] pa, input logic [63:0] flags);
    return (64'h1 << 63) | (64'(sz) << 61) | (pa & 64'h1FF_FFFF_E000) | flags;
  endfunction

  // Compare at the falling edge, then advance the model to the state after the next rising edge.
  task automatic tick(input string req);
    logic [12:0] ctx;
    int found, pb;
    logic eHit, eGrant, eWr, eTrap, ftP, ftS, ftN, df, pf, isSt, isNf;
    logic [7:0]  eType;
    logic [63:0] ePa, st;
    logic [1:0]  kind;
    @(negedge clk);
    #1;
    kind = (ctxSel == 2'd3) ? 2'd2 : ctxSel;
    ctx  = (kind == 2'd0) ? priCtx : (kind == 2'd1) ? secCtx : 13'd0;
    found = -1;
    for (int i = 0; i < 64; i++) begin
      pb = 13 + 3 * int'(mTte[i][62:61]);
      if (found < 0 && mTte[i][63] && ((vaddr >> pb) == (mTag[i] >> pb))
          && (mTte[i][0] || mTag[i][12:0] == ctx)) found = i;
    end
    isSt = (accKind == 2'd1);
    isNf = (accKind == 2'd2);
    eHit = 0; eGrant = 0; eWr = 0; eTrap = 0; eType = 0; ePa = 0;
    ftP = 0; ftS = 0; ftN = 0; df = 0; pf = 0;
    if (lookupEn && !mmuEnable) begin
      eGrant = 1; eWr = 1; ePa = vaddr & 64'h1FF_FFFF_FFFF;
    end else if (lookupEn) begin
      if (found < 0) begin
        eTrap = 1; eType = 8'h68;
      end else begin
        eHit = 1;
        ftP = mTte[found][2] && !privMode;
        ftS = isNf && mTte[found][3];
        ftN = !isNf && mTte[found][60];
        df  = ftP || ftS || ftN;
        pf  = !df && isSt && !mTte[found][1];
        if (df) begin eTrap = 1; eType = 8'h09; end
        else if (pf) begin eTrap = 1; eType = 8'h6C; end
        else begin
          pb = 13 + 3 * int'(mTte[found][62:61]);
          eGrant = 1;
          eWr = mTte[found][1];
          ePa = ((mTte[found] >> pb) << pb) | (vaddr & ((64'h1 << pb) - 1));
          ePa = ePa & 64'h1FF_FFFF_FFFF;
        end
      end
    end
    chk(req, "hit", 64'(hit), 64'(eHit));
    chk(req, "grant", 64'(grant), 64'(eGrant));
    chk(req, "permWrite", 64'(permWrite), 64'(eWr));
    chk(req, "paddr", 64'(paddr), ePa);
    chk(req, "trapValid", 64'(trapValid), 64'(eTrap));
    chk(req, "trapType", 64'(trapType), 64'(eType));
    chk(req, "faultStatus", faultStatus, mStatus);
    chk(req, "faultAddr", faultAddr, mFaddr);
    chk(req, "tagAccess", tagAccess, mTagAcc);
    chk(req, "rdTte", rdTte, mTte[rdIdx]);
    // next state
    if (lookupEn && mmuEnable) begin
      if (found < 0 || df || pf) mTagAcc = {vaddr[63:13], ctx};
      if (found >= 0 && (df || pf)) begin
        st = 64'h1;
        st[1] = mStatus[0]; st[2] = isSt; st[3] = privMode; st[5:4] = kind;
        st[7] = ftP; st[8] = ftS; st[11] = ftN; st[24] = isNf;
        mStatus = st;
        mFaddr  = vaddr;
      end
      if (found >= 0 && !df && !pf) mTte[found][41] = 1'b1;
    end
    if (wrEn) begin
      mTag[wrIdx] = wrTag;
      mTte[wrIdx] = wrTte;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic putEntry(input int idx, input logic [63:0] tag, input logic [63:0] tte);
    lookupEn = 0; wrEn = 1; wrIdx = 6'(idx); wrTag = tag; wrTte = tte; rdIdx = 6'(idx);
    tick("R14");
    wrEn = 0;
    tick("R14");
  endtask

  task automatic look(input string req, input logic [63:0] va, input logic [1:0] acc,
                      input logic [1:0] sel, input logic pv);
    lookupEn = 1; vaddr = va; accKind = acc; ctxSel = sel; privMode = pv;
    tick(req);
    lookupEn = 0;
  endtask

  initial begin
    #100000;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin mTag[i] = '0; mTte[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state, empty buffer misses
    rdIdx = 6'd17;
    tick("R1");
    priCtx = 13'd5; secCtx = 13'd6;
    look("R1", 64'h0000_0000_1234_A000, 2'd0, 2'd0, 1'b1);
    // R14 fill entries
    putEntry(0, 64'h0000_0000_1234_A000 | 64'd5, mkTte(0, 64'h122_3344_6000, 64'h2));
    putEntry(1, 64'h0000_0040_0001_0000 | 64'h1ABC, mkTte(1, 64'h155_5550_0000, 64'h1));
    putEntry(2, 64'hFFFF_8000_0008_0000 | 64'd7, mkTte(2, 64'h0AA_AAA8_0000, 64'h6));
    putEntry(3, 64'h0000_0000_8040_0000, mkTte(3, 64'h1F0_0C00_0000, 64'hA));
    putEntry(4, 64'h0000_0000_5555_4000 | 64'd5, mkTte(0, 64'h033_0000_2000, 64'h1 << 60));
    putEntry(5, 64'h0000_0000_7777_0000 | 64'd9, mkTte(0, 64'h0AA_0000_0000, 64'h2));
    putEntry(6, 64'h0000_0000_6666_0000 | 64'd5, mkTte(0, 64'h011_0000_4000, (64'h1 << 60) | 64'h4));
    putEntry(9, 64'h0000_0000_7777_0000 | 64'd9, mkTte(0, 64'h0BB_0000_0000, 64'h2));
    // R2 page sizes and boundaries, R4 address composition
    rdIdx = 6'd0;
    look("R2", 64'h0000_0000_1234_BFFF, 2'd0, 2'd0, 1'b1);
    tick("R12");
    look("R2", 64'h0000_0000_1234_C000, 2'd0, 2'd0, 1'b1);
    look("R4", 64'h0000_0040_0001_FFF8, 2'd0, 2'd2, 1'b1);
    look("R2", 64'h0000_0040_0002_0000, 2'd0, 2'd2, 1'b1);
    look("R4", 64'h0000_0000_807F_FFFC, 2'd1, 2'd2, 1'b1);
    look("R2", 64'hFFFF_8000_000F_FFF0, 2'd0, 2'd0, 1'b1);
    // R3 context selection and global entries
    priCtx = 13'd7;
    look("R4", 64'hFFFF_8000_000F_FFF0, 2'd1, 2'd0, 1'b1);
    look("R3", 64'h0000_0000_1234_A010, 2'd0, 2'd1, 1'b1);
    secCtx = 13'd5;
    look("R3", 64'h0000_0000_1234_A010, 2'd0, 2'd1, 1'b1);
    look("R3", 64'h0000_0040_0001_0004, 2'd0, 2'd3, 1'b0);
    // R5 lowest index wins, R12 used bit
    priCtx = 13'd9; rdIdx = 6'd5;
    look("R5", 64'h0000_0000_7777_0123, 2'd0, 2'd0, 1'b0);
    tick("R12");
    rdIdx = 6'd9;
    tick("R5");
    // R6 data faults, R8 status, R9 overflow
    priCtx = 13'd7;
    look("R6", 64'hFFFF_8000_0008_0040, 2'd0, 2'd0, 1'b0);
    tick("R8");
    look("R6", 64'h0000_0000_8040_1000, 2'd2, 2'd2, 1'b1);
    tick("R9");
    priCtx = 13'd5;
    look("R6", 64'h0000_0000_5555_4008, 2'd1, 2'd0, 1'b0);
    look("R6", 64'h0000_0000_6666_0000, 2'd0, 2'd0, 1'b0);
    look("R6", 64'h0000_0000_5555_4008, 2'd2, 2'd0, 1'b1);
    // R7 protection trap, R11 tag access
    look("R7", 64'h0000_0040_0001_2000, 2'd1, 2'd0, 1'b1);
    tick("R11");
    look("R7", 64'h0000_0040_0001_2000, 2'd0, 2'd0, 1'b1);
    // R10 miss keeps status
    look("R10", 64'h0000_1111_2222_0000, 2'd1, 2'd1, 1'b0);
    tick("R10");
    // R13 passthrough
    mmuEnable = 0;
    look("R13", 64'hFFFF_FFFF_DEAD_BEEF, 2'd1, 2'd0, 1'b0);
    tick("R13");
    mmuEnable = 1;
    // R14 write collides with used-bit update on same entry
    priCtx = 13'd5; rdIdx = 6'd0;
    wrEn = 1; wrIdx = 6'd0; wrTag = 64'h0000_0000_1234_A000 | 64'd5;
    wrTte = mkTte(0, 64'h122_3344_8000, 64'h2);
    look("R14", 64'h0000_0000_1234_A100, 2'd0, 2'd0, 1'b1);
    wrEn = 0;
    tick("R14");
    // mixed stimulus over all entries
    for (int n = 0; n < 300; n++) begin
      int k;
      logic [63:0] va;
      k = $urandom_range(0, 9);
      va = mTag[k] ^ 64'($urandom_range(0, 32'h7F_FFFF));
      if ($urandom_range(0, 7) == 0) va = va ^ 64'h0000_0100_0000_0000;
      priCtx = 13'(($urandom_range(0, 3) == 0) ? 0 : mTag[k][12:0]);
      secCtx = 13'($urandom_range(4, 9));
      rdIdx  = 6'(k);
      mmuEnable = ($urandom_range(0, 15) != 0);
      look("R6", va, 2'($urandom_range(0, 2)), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule